// File: doc/BRIEF.md
# USB OTG Interrupt Wrapper

This block sits beside a USB on-the-go controller and turns its many event lines into one interrupt request for a processor. Endpoint transmit events, endpoint receive events, eight core events and a change of the VBUS drive request are latched into a sticky source word. Software reads a per-bit mask, a masked view and the raw source over a simple 32-bit register bus. Software can also set or clear source and mask bits through write-one alias addresses.

The interrupt output is a one-cycle pulse. After it fires it stays low until software writes the end-of-interrupt address, and only then can a pending masked event raise it again. A control bit starts a soft reset of the wrapper state. A status word shows the live VBUS drive level, and a fixed nonzero revision word lets software detect that the block is present and clocked.

Top module: `usb_irq_wrapper`

## Requirements
- R1: Power-on reset leaves the source (0x20), mask (0x2C) and masked (0x38) words at zero and `irq` low. The revision word at 0x00 always reads the nonzero parameter `REVISION`.
- R2: Source bit positions are fixed. `tx_evt[i]` sets bit i (bits 4:0). `rx_evt[j]` sets bit 9+j (bits 12:9). `core_evt[k]` sets bit 16+k (bits 23:16). Bit 24 is set by any change of `vbus_drive` from its value in the previous cycle, and that value is 0 after reset. All other bits, bit 8 included, read 0 and cannot be set.
- R3: Bit 0 of the status word at 0x08 equals `vbus_drive` in the same cycle. Its other bits read 0.
- R4: A write to 0x24 sets the source bits written as one, and a write to 0x28 clears them. Zero bits leave the source unchanged. Source bits hold until cleared. A hardware event in the same cycle as a clear leaves its bit set. Writes to 0x20 are ignored.
- R5: A write to 0x30 sets the mask bits written as one, and a write to 0x34 clears them. Zero bits have no effect. Only the bits valid in R2 are kept. Writes to 0x2C are ignored.
- R6: The word at 0x38 reads as the bitwise AND of the source and mask words.
- R7: When the wrapper is armed and the masked word is nonzero, `irq` is high for exactly one cycle, starting at the next clock edge. The wrapper then disarms.
- R8: A write of any value to 0x3C re-arms the wrapper. If the masked word is still nonzero, `irq` pulses again in the second cycle after the write.
- R9: Writing 1 to bit 0 of the control word at 0x04 clears the source and mask, re-arms the wrapper and holds `irq` low at the next edge. This takes priority over events in the same cycle. The control word reads 0.
- R10: The emulation word at 0x0C keeps its low 3 bits as last written. Power-on reset clears them, but a soft reset does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_evt | input | 5 | Transmit endpoint event pulses |
| rx_evt | input | 4 | Receive endpoint event pulses |
| core_evt | input | 8 | Core event pulses |
| vbus_drive | input | 1 | VBUS drive request level |
| irq | output | 1 | Interrupt request pulse |

## Verification
The hardest case to reach from the ports is a masked event that is still pending while the wrapper is disarmed, followed by a re-arm. In that case the second pulse has to appear exactly two cycles after the end-of-interrupt write. A directed sequence builds this case by unmasking a latched event, letting the pulse fire, idling, and then writing the end-of-interrupt address. A clear write that collides with a hardware event on the same bit is also forced by a directed step. Seeded random traffic then mixes alias writes, soft resets and sparse events, and a cycle-accurate bench model checks every pulse.

// File: rtl/usb_irq_wrapper.sv
module usb_irq_wrapper #(
  parameter logic [31:0] REVISION = 32'h4EA1_0200,
  parameter int          AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [4:0]    tx_evt,
  input  logic [3:0]    rx_evt,
  input  logic [7:0]    core_evt,
  input  logic          vbus_drive,
  output logic          irq
);

  localparam logic [AW-1:0] A_REV    = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL   = AW'(8'h04);
  localparam logic [AW-1:0] A_STAT   = AW'(8'h08);
  localparam logic [AW-1:0] A_EMU    = AW'(8'h0C);
  localparam logic [AW-1:0] A_SRC    = AW'(8'h20);
  localparam logic [AW-1:0] A_SSET   = AW'(8'h24);
  localparam logic [AW-1:0] A_SCLR   = AW'(8'h28);
  localparam logic [AW-1:0] A_MASK   = AW'(8'h2C);
  localparam logic [AW-1:0] A_MSET   = AW'(8'h30);
  localparam logic [AW-1:0] A_MCLR   = AW'(8'h34);
  localparam logic [AW-1:0] A_MSKD   = AW'(8'h38);
  localparam logic [AW-1:0] A_EOI    = AW'(8'h3C);
  localparam logic [31:0]   VALID    = 32'h01FF_1E1F;

  logic [31:0] src_q, mask_q;
  logic        armed_q, irq_q, vbus_q;
  logic [2:0]  emu_q;

  wire soft_rst = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
  wire eoi_wr   = bus_wr && bus_addr == A_EOI;
  wire vbus_chg = vbus_drive != vbus_q;

  wire [31:0] hw_evt  = {7'b0, vbus_chg, core_evt, 3'b0, rx_evt, 1'b0, 3'b0, tx_evt};
  wire [31:0] s_set   = (bus_wr && bus_addr == A_SSET) ? bus_wdata : 32'b0;
  wire [31:0] s_clr   = (bus_wr && bus_addr == A_SCLR) ? bus_wdata : 32'b0;
  wire [31:0] m_set   = (bus_wr && bus_addr == A_MSET) ? bus_wdata : 32'b0;
  wire [31:0] m_clr   = (bus_wr && bus_addr == A_MCLR) ? bus_wdata : 32'b0;
  wire [31:0] masked  = src_q & mask_q;
  wire        fire    = armed_q && (|masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
      vbus_q  <= 1'b0;
      emu_q   <= '0;
    end else begin
      vbus_q <= vbus_drive;
      if (bus_wr && bus_addr == A_EMU) emu_q <= bus_wdata[2:0];
      if (soft_rst) begin
        src_q   <= '0;
        mask_q  <= '0;
        armed_q <= 1'b1;
        irq_q   <= 1'b0;
      end else begin
        src_q   <= (((src_q | s_set) & ~s_clr) | hw_evt) & VALID;
        mask_q  <= ((mask_q | m_set) & ~m_clr) & VALID;
        irq_q   <= fire;
        armed_q <= eoi_wr ? 1'b1 : (fire ? 1'b0 : armed_q);
      end
    end
  end

  assign irq = irq_q;

  always_comb begin
    unique case (bus_addr)
      A_REV:   bus_rdata = REVISION;
      A_STAT:  bus_rdata = {31'b0, vbus_drive};
      A_EMU:   bus_rdata = {29'b0, emu_q};
      A_SRC:   bus_rdata = src_q;
      A_MASK:  bus_rdata = mask_q;
      A_MSKD:  bus_rdata = masked;
      default: bus_rdata = 32'b0;
    endcase
  end

  initial a_r1_rev_nonzero: assert (REVISION != 32'b0);

  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt[0] && !soft_rst) |=> src_q[0]);

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(src_q & mask_q)));

  a_r7_quiet_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi_wr && !soft_rst) |=> (!armed_q && !irq));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !armed_q && !eoi_wr) |=> !irq);

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (src_q == 32'b0 && mask_q == 32'b0 && !irq && armed_q));

  a_r3_status_live: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> (bus_rdata == {31'b0, vbus_drive}));

endmodule

// File: tb/usb_irq_wrapper_bench.sv
module usb_irq_wrapper_bench;
  localparam logic [31:0] REV   = 32'h4EA1_0200;
  localparam logic [31:0] VALID = 32'h01FF_1E1F;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [4:0] tx_evt = 0;
  logic [3:0] rx_evt = 0;
  logic [7:0] core_evt = 0;
  logic vbus_drive = 0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_src = 0, m_mask = 0;
  logic m_armed = 1, m_irq = 0, m_vq = 0;
  logic [2:0] m_emu = 0;

  always #4 clk = ~clk;

  usb_irq_wrapper #(.REVISION(REV), .AW(8)) u_usb_irq_wrapper (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .core_evt(core_evt), .vbus_drive(vbus_drive), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [4:0] t, input logic [3:0] r, input logic [7:0] c,
                     input logic v);
    logic [31:0] hw, ss, sc, ms, mc, n_src, n_mask;
    logic fire, n_armed, n_irq;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    tx_evt = t; rx_evt = r; core_evt = c; vbus_drive = v;
    hw = {7'b0, v != m_vq, c, 3'b0, r, 1'b0, 3'b0, t};
    ss = (w && a == 8'h24) ? d : 0;
    sc = (w && a == 8'h28) ? d : 0;
    ms = (w && a == 8'h30) ? d : 0;
    mc = (w && a == 8'h34) ? d : 0;
    fire = m_armed && |(m_src & m_mask);
    if (w && a == 8'h04 && d[0]) begin
      n_src = 0; n_mask = 0; n_armed = 1; n_irq = 0;
    end else begin
      n_src   = (((m_src | ss) & ~sc) | hw) & VALID;
      n_mask  = ((m_mask | ms) & ~mc) & VALID;
      n_irq   = fire;
      n_armed = (w && a == 8'h3C) ? 1'b1 : (fire ? 1'b0 : m_armed);
    end
    if (w && a == 8'h0C) m_emu = d[2:0];
    @(posedge clk); #2;
    m_src = n_src; m_mask = n_mask; m_armed = n_armed; m_irq = n_irq; m_vq = v;
    bus_wr = 0; tx_evt = 0; rx_evt = 0; core_evt = 0;
    chk("R7 R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle(); cyc(0, 8'h00, 0, 0, 0, 0, vbus_drive); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1, a, d, 0, 0, 0, vbus_drive); endtask

  task automatic peek(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    peek("R1 revision", 8'h00, REV);
    peek("R1 source", 8'h20, 0);
    peek("R1 mask", 8'h2C, 0);
    peek("R1 masked", 8'h38, 0);
    chk("R1 irq low", {31'b0, irq}, 0);

    cyc(0, 0, 0, 5'h15, 4'hA, 8'h81, 0);
    peek("R2 event layout", 8'h20, 32'h0081_1415);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    peek("R2 valid bits, bit 8 zero", 8'h20, 32'h01FF_1E1F);
    wr(8'h20, 32'h0);
    peek("R4 direct source write ignored", 8'h20, 32'h01FF_1E1F);
    cyc(1, 8'h28, 32'hFFFF_FFFF, 5'h01, 0, 0, 0);
    peek("R4 event beats clear", 8'h20, 32'h0000_0001);

    cyc(0, 0, 0, 0, 0, 0, 1);
    peek("R3 status level", 8'h08, 32'h1);
    peek("R2 vbus change bit 24", 8'h20, 32'h0100_0001);
    wr(8'h28, 32'h0100_0000);
    peek("R4 clear bit 24", 8'h20, 32'h1);

    wr(8'h30, 32'h5);
    peek("R5 mask set", 8'h2C, 32'h5);
    idle(); chk("R7 pulse", {31'b0, irq}, 1);
    idle(); chk("R7 pulse ends", {31'b0, irq}, 0);
    wr(8'h30, 32'h2);
    peek("R5 zero bits no effect", 8'h2C, 32'h7);
    wr(8'h34, 32'h4);
    peek("R5 mask clear", 8'h2C, 32'h3);
    wr(8'h2C, 32'h0);
    peek("R5 direct mask write ignored", 8'h2C, 32'h3);
    peek("R6 masked view", 8'h38, 32'h1);
    chk("R7 disarmed stays low", {31'b0, irq}, 0);
    wr(8'h3C, 32'h0);
    chk("R8 eoi cycle low", {31'b0, irq}, 0);
    idle(); chk("R8 rearmed pulse", {31'b0, irq}, 1);
    idle(); chk("R8 pulse ends", {31'b0, irq}, 0);

    wr(8'h0C, 32'h5);
    cyc(1, 8'h04, 32'h1, 5'h1F, 0, 0, 1);
    peek("R9 source cleared", 8'h20, 0);
    peek("R9 mask cleared", 8'h2C, 0);
    peek("R9 control reads 0", 8'h04, 0);
    peek("R10 emulation survives soft reset", 8'h0C, 32'h5);
    peek("R1 revision after soft reset", 8'h00, REV);
    chk("R9 irq low", {31'b0, irq}, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic w;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: a = 8'h24; 1: a = 8'h28; 2: a = 8'h30; 3: a = 8'h34;
        4: a = 8'h3C; 5: a = 8'h0C; 6: a = 8'h20; 7: a = 8'h2C;
        8: a = 8'h04; default: a = 8'h00;
      endcase
      w = ($urandom_range(0, 2) == 0);
      d = $urandom;
      if (a == 8'h04 && $urandom_range(0, 15) != 0) d[0] = 1'b0;
      cyc(w, a, d,
          ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'h0,
          ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0,
          ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h0,
          ($urandom_range(0, 19) == 0) ? ~vbus_drive : vbus_drive);
      if (i % 7 == 0) begin
        peek("R4 random source", 8'h20, m_src);
        peek("R5 random mask", 8'h2C, m_mask);
        peek("R6 random masked", 8'h38, m_src & m_mask);
        peek("R3 random status", 8'h08, {31'b0, vbus_drive});
        peek("R10 random emulation", 8'h0C, {29'b0, m_emu});
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule